// File: doc/BRIEF.md
# Raw Video Frame Capture Controller

This block decides, frame by frame, whether words arriving on a raw video input are passed on to a downstream FIFO. The input side gives a start-of-frame strobe, a data-valid qualifier and an end-of-block strobe. The block answers with a FIFO write-enable. A frame is taken whole or not at all, because capture only begins on a start-of-frame. Once a frame begins, every valid word up to and including its end-of-block cycle is written.

Each captured frame sets a sticky frame-complete flag, and software clears it with a one-cycle clear strobe. Setting the flag also raises an interrupt-pending bit, which an acknowledge strobe clears. The pending bit drives an interrupt output through an enable. Two configuration bits pick the mode:
- **Limited (default):** a bounded number of further frames are taken while the flag is still set. Capture then halts until the flag is cleared.
- **Single-shot:** capture halts as soon as the flag is set.
- **Continuous:** the flag is ignored.
- **Reserved:** the fourth encoding captures nothing.

A halted output tells software when incoming data is being thrown away.

Top module: `vcap_frame_ctrl`

## Requirements
- R1: While `cap_en` is 0, `fifo_wr_en` stays 0, `halted` reads 1 and `frm_done` is not set.
- R2: Capture starts only in a cycle with `sof`=1. In that cycle and after it, `fifo_wr_en` equals `data_vld`, through the cycle with `blk_end`=1. Valid data before the start-of-frame is not written.
- R3: When a captured frame ends (`blk_end`=1), `frm_done` and `irq_pend` both read 1 from the next cycle. `frm_done` falls only after a `done_clr` strobe.
- R4: In limited mode (`cfg_cont`=0, `cfg_single`=0) with `GRACE_FRAMES`=1, exactly one frame is captured after `frm_done` is set. If the flag is still set when that frame ends, later frames are dropped and `halted` reads 1.
- R5: In limited mode, clearing `frm_done` lets capture resume at the next start-of-frame. The count of extra frames then starts again from zero.
- R6: In single-shot mode (`cfg_cont`=0, `cfg_single`=1), no frame is captured while `frm_done` is 1. Capture resumes at the first start-of-frame after the clear.
- R7: In continuous mode (`cfg_cont`=1, `cfg_single`=0), every frame is captured whatever the state of `frm_done`, and `halted` stays 0.
- R8: The reserved setting (`cfg_cont`=1, `cfg_single`=1) captures no frame and leaves `halted` at 1.
- R9: A `done_clr` strobe in the same cycle as a frame end leaves `frm_done` at 1.
- R10: `irq` is `irq_pend` gated by `irq_en`. With `irq_en`=0, `irq` stays 0 while `irq_pend` is still visible. `irq_ack` clears `irq_pend`.
- R11: `halted` reads 1 exactly when no frame is in progress and a start-of-frame would not be accepted. `fifo_wr_en` is never 1 while `halted` is 1.
- R12: Dropping `cap_en` in the middle of a frame aborts the frame. No further words are written, the frame end does not set `frm_done`, and capture does not resume until the next start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture enable |
| cfg_cont | input | 1 | Continuous-mode configuration bit |
| cfg_single | input | 1 | Single-shot configuration bit |
| irq_en | input | 1 | Interrupt output enable |
| sof | input | 1 | Start-of-frame strobe |
| blk_end | input | 1 | End-of-data-block strobe (last cycle of frame) |
| data_vld | input | 1 | Input word valid |
| done_clr | input | 1 | Software clear strobe for `frm_done` |
| irq_ack | input | 1 | Software clear strobe for `irq_pend` |
| fifo_wr_en | output | 1 | Write-enable to the downstream FIFO |
| frm_done | output | 1 | Sticky frame-complete flag |
| irq_pend | output | 1 | Capture-complete interrupt status |
| irq | output | 1 | Masked capture-complete interrupt |
| halted | output | 1 | Incoming data is being dropped |

## Verification
The hardest case to reach is the end of the limited-mode grace window. It needs a captured frame with the flag clear, then a second frame with the flag still set, and only then a third frame that must be dropped. The stimulus sends these frames back to back without clearing. It then clears and repeats the sequence, to show that the grace count starts again. A clear strobe is also placed exactly on a frame's end-of-block cycle to test the set-over-clear priority. An abort is made by pulling the enable low between the start and the end of a frame.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

   typedef enum logic [1:0] {
      CAP_LIMITED = 2'd0,
      CAP_SINGLE  = 2'd1,
      CAP_CONT    = 2'd2,
      CAP_RSVD    = 2'd3
   } cap_mode_e;

   function automatic cap_mode_e decode_mode(input logic cont, input logic single);
      case ({cont, single})
         2'b00:   return CAP_LIMITED;
         2'b01:   return CAP_SINGLE;
         2'b10:   return CAP_CONT;
         default: return CAP_RSVD;
      endcase
   endfunction

endpackage

// File: rtl/vcap_mode_dec.sv
module vcap_mode_dec
   import vcap_pkg::*;
(
   input  logic      cfg_cont,
   input  logic      cfg_single,
   output cap_mode_e mode_o
);
   always_comb mode_o = decode_mode(cfg_cont, cfg_single);
endmodule

// File: rtl/vcap_status.sv
module vcap_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic ack_i,
   input  logic irq_en,
   output logic flag_o,
   output logic pend_o,
   output logic irq_o
);
   // hardware set always wins over a same-cycle software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         if (set_i)      flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
         if (set_i)      pend_o <= 1'b1;
         else if (ack_i) pend_o <= 1'b0;
      end
   end

   always_comb irq_o = pend_o & irq_en;
endmodule

// File: rtl/vcap_gate.sv
module vcap_gate
   import vcap_pkg::*;
#(
   parameter int GRACE_FRAMES = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cap_en,
   input  cap_mode_e mode,
   input  logic      sof,
   input  logic      blk_end,
   input  logic      data_vld,
   input  logic      flag,
   output logic      wr_en,
   output logic      frame_end,
   output logic      in_frame,
   output logic      halted
);
   localparam int CNT_W = (GRACE_FRAMES < 2) ? 1 : $clog2(GRACE_FRAMES + 1);

   logic go;
   logic accept;
   logic grace_full;
   logic grace_step;

   generate
      if (GRACE_FRAMES < 1) begin : g_bad
         $error("vcap_gate: GRACE_FRAMES must be at least 1");
      end
   endgenerate

   assign grace_step = frame_end & flag & (mode == CAP_LIMITED) & ~grace_full;

   generate
      if (GRACE_FRAMES == 1) begin : g_bit
         logic used_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          used_q <= 1'b0;
            else if (!flag)      used_q <= 1'b0;
            else if (grace_step) used_q <= 1'b1;
         end
         assign grace_full = used_q;
      end else begin : g_cnt
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GRACE_FRAMES);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (!flag)      cnt_q <= '0;
            else if (grace_step) cnt_q <= cnt_q + 1'b1;
         end
         assign grace_full = (cnt_q == LIMIT);
      end
   endgenerate

   always_comb begin
      case (mode)
         CAP_LIMITED: go = ~(flag & grace_full);
         CAP_SINGLE:  go = ~flag;
         CAP_CONT:    go = 1'b1;
         default:     go = 1'b0;
      endcase
      go = go & cap_en;
   end

   assign accept    = sof & go;
   assign frame_end = cap_en & in_frame & blk_end;
   assign wr_en     = data_vld & cap_en & (in_frame | accept);
   assign halted    = ~(cap_en & in_frame) & ~go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_frame <= 1'b0;
      else        in_frame <= cap_en & ((accept & ~blk_end) | (in_frame & ~blk_end));
   end
endmodule

// File: rtl/vcap_frame_ctrl.sv
module vcap_frame_ctrl
   import vcap_pkg::*;
#(
   parameter int GRACE_FRAMES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic cfg_cont,
   input  logic cfg_single,
   input  logic irq_en,
   input  logic sof,
   input  logic blk_end,
   input  logic data_vld,
   input  logic done_clr,
   input  logic irq_ack,
   output logic fifo_wr_en,
   output logic frm_done,
   output logic irq_pend,
   output logic irq,
   output logic halted
);
   cap_mode_e mode;
   logic      frame_end;
   logic      in_frame_q;

   vcap_mode_dec u_dec (
      .cfg_cont   (cfg_cont),
      .cfg_single (cfg_single),
      .mode_o     (mode)
   );

   vcap_gate #(.GRACE_FRAMES(GRACE_FRAMES)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .mode      (mode),
      .sof       (sof),
      .blk_end   (blk_end),
      .data_vld  (data_vld),
      .flag      (frm_done),
      .wr_en     (fifo_wr_en),
      .frame_end (frame_end),
      .in_frame  (in_frame_q),
      .halted    (halted)
   );

   vcap_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (frame_end),
      .clr_i  (done_clr),
      .ack_i  (irq_ack),
      .irq_en (irq_en),
      .flag_o (frm_done),
      .pend_o (irq_pend),
      .irq_o  (irq)
   );
endmodule

// File: rtl/vcap_frame_ctrl_chk.sv
module vcap_frame_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cap_en,
   input logic cfg_cont,
   input logic cfg_single,
   input logic irq_en,
   input logic blk_end,
   input logic done_clr,
   input logic fifo_wr_en,
   input logic frm_done,
   input logic irq_pend,
   input logic irq,
   input logic halted,
   input logic in_frame_q
);
   // R1
   disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |-> (!fifo_wr_en && halted));

   // R3 R9
   frame_end_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && in_frame_q && blk_end) |=> (frm_done && irq_pend));

   // R3
   flag_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frm_done) |-> $past(done_clr));

   // R6
   single_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_cont && cfg_single && frm_done && !in_frame_q) |-> !fifo_wr_en);

   // R7
   cont_never_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cont && !cfg_single && cap_en) |-> !halted);

   // R8
   reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cont && cfg_single && !in_frame_q) |-> (!fifo_wr_en && halted));

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   // R11
   no_write_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !fifo_wr_en);
endmodule

bind vcap_frame_ctrl vcap_frame_ctrl_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cap_en     (cap_en),
   .cfg_cont   (cfg_cont),
   .cfg_single (cfg_single),
   .irq_en     (irq_en),
   .blk_end    (blk_end),
   .done_clr   (done_clr),
   .fifo_wr_en (fifo_wr_en),
   .frm_done   (frm_done),
   .irq_pend   (irq_pend),
   .irq        (irq),
   .halted     (halted),
   .in_frame_q (in_frame_q)
);

// File: tb/vcap_frame_ctrl_tb_top.sv
module vcap_frame_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap_en = 0, cfg_cont = 0, cfg_single = 0, irq_en = 0;
   logic sof = 0, blk_end = 0, data_vld = 0, done_clr = 0, irq_ack = 0;
   logic fifo_wr_en, frm_done, irq_pend, irq, halted;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   vcap_frame_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cfg_cont(cfg_cont),
      .cfg_single(cfg_single), .irq_en(irq_en), .sof(sof), .blk_end(blk_end),
      .data_vld(data_vld), .done_clr(done_clr), .irq_ack(irq_ack),
      .fifo_wr_en(fifo_wr_en), .frm_done(frm_done), .irq_pend(irq_pend),
      .irq(irq), .halted(halted)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // one frame of len valid words; exp is the expected write-enable
   task automatic frame(input int len, input logic exp, input string req, input bit clr_last = 0);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         sof = (i == 0); blk_end = (i == len - 1); data_vld = 1'b1;
         done_clr = clr_last && (i == len - 1);
         #1 check(req, fifo_wr_en, exp);
      end
      @(negedge clk);
      sof = 0; blk_end = 0; data_vld = 0; done_clr = 0;
      #1;
   endtask

   task automatic pulse_clr();
      @(negedge clk); done_clr = 1;
      @(negedge clk); done_clr = 0;
      #1;
   endtask

   task automatic pulse_ack();
      @(negedge clk); irq_ack = 1;
      @(negedge clk); irq_ack = 0;
      #1;
   endtask

   task automatic t_reset();
      #1;
      check("R1 reset frm_done", frm_done, 0);
      check("R1 reset irq_pend", irq_pend, 0);
      check("R1 reset wr_en", fifo_wr_en, 0);
      check("R1 reset halted", halted, 1);
   endtask

   task automatic t_disabled();
      cap_en = 0;
      frame(4, 0, "R1 disabled write");
      check("R1 disabled flag", frm_done, 0);
      check("R1 disabled halted", halted, 1);
   endtask

   task automatic t_sof_align();
      cap_en = 1; cfg_cont = 0; cfg_single = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); data_vld = 1;
         #1 check("R2 pre-sof data dropped", fifo_wr_en, 0);
      end
      frame(5, 1, "R2 frame written");
      check("R3 flag set", frm_done, 1);
      check("R3 irq_pend set", irq_pend, 1);
      irq_en = 1; #1 check("R10 irq enabled", irq, 1);
      irq_en = 0; #1 check("R10 irq masked", irq, 0);
      check("R10 pend visible while masked", irq_pend, 1);
      pulse_ack();
      check("R10 ack clears pend", irq_pend, 0);
      check("R3 flag survives ack", frm_done, 1);
   endtask

   task automatic t_limited_halt();
      frame(3, 1, "R4 grace frame written");
      check("R4 flag still set", frm_done, 1);
      check("R4 halted after grace", halted, 1);
      frame(3, 0, "R4 third frame dropped");
      pulse_clr();
      check("R4 flag cleared", frm_done, 0);
      check("R11 not halted after clear", halted, 0);
   endtask

   task automatic t_limited_rearm();
      frame(2, 1, "R5 first frame after clear");
      frame(2, 1, "R5 grace frame after clear");
      frame(2, 0, "R5 grace used again");
      pulse_clr();
      frame(2, 1, "R5 resume after clear");
      pulse_clr();
   endtask

   task automatic t_collide();
      frame(3, 1, "R9 frame with clear on end", 1);
      check("R9 set wins over clear", frm_done, 1);
      pulse_clr();
      check("R9 later clear works", frm_done, 0);
   endtask

   task automatic t_single();
      cfg_single = 1; cfg_cont = 0;
      frame(3, 1, "R6 first frame");
      check("R6 flag set", frm_done, 1);
      check("R6 halted", halted, 1);
      frame(3, 0, "R6 frame dropped while flag set");
      pulse_clr();
      check("R6 not halted after clear", halted, 0);
      frame(3, 1, "R6 resume after clear");
      pulse_clr();
   endtask

   task automatic t_cont();
      cfg_single = 0; cfg_cont = 1;
      frame(2, 1, "R7 frame 1");
      frame(2, 1, "R7 frame 2");
      frame(2, 1, "R7 frame 3");
      check("R7 flag set", frm_done, 1);
      check("R7 never halted", halted, 0);
      irq_en = 1; #1 check("R10 cont irq", irq, 1);
      irq_en = 0; #1 check("R10 cont irq masked", irq, 0);
      pulse_ack(); pulse_clr();
   endtask

   task automatic t_reserved();
      cfg_single = 1; cfg_cont = 1;
      #1 check("R8 reserved halted", halted, 1);
      frame(3, 0, "R8 reserved no capture");
      check("R8 reserved no flag", frm_done, 0);
      cfg_single = 0; cfg_cont = 0;
   endtask

   task automatic t_abort();
      @(negedge clk); sof = 1; data_vld = 1;
      #1 check("R12 frame start written", fifo_wr_en, 1);
      @(negedge clk); sof = 0;
      #1 check("R12 mid frame written", fifo_wr_en, 1);
      @(negedge clk); cap_en = 0;
      #1 check("R12 write stops on disable", fifo_wr_en, 0);
      @(negedge clk); blk_end = 1;
      @(negedge clk); blk_end = 0; cap_en = 1;
      #1 check("R12 aborted frame sets no flag", frm_done, 0);
      check("R12 no mid-frame resume", fifo_wr_en, 0);
      @(negedge clk); data_vld = 0;
      frame(2, 1, "R12 next sof captured");
      pulse_clr();
   endtask

   initial begin
      #200000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      t_disabled();
      t_sof_align();
      t_limited_halt();
      t_limited_rearm();
      t_collide();
      t_single();
      t_cont();
      t_reserved();
      t_abort();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule